// File: doc/BRIEF.md
# Configurable UART with Echo Path

This block is a full-duplex asynchronous serial transceiver that a local controller drives through four byte-wide registers. Each direction has one word of buffering. The transmitter has a holding register that feeds a shift register. The receiver has a shift register that feeds a data register. A transmit interrupt pulse tells the controller when the holding register is free again.

The frame format is set at run time. The word can be 7 or 8 data bits, with an optional parity bit of either sense. The polarity of each line can be inverted on its own. A hardware echo mode drives the outgoing line straight from the incoming one. A programmable divider makes a tick at 16 times the bit rate. The receiver uses these ticks to find the middle of each bit and to reject start pulses that are too short.

Top module: `uart_echo_core`

## Requirements
- R1: A frame is sent as a low start bit, then the data bits least significant first, then the parity bit if enabled, then a high stop bit. Control bit 2 set gives 8 data bits, clear gives 7.
- R2: With control bit 3 set, a parity bit is added on transmit and checked on receive. It is even parity when control bit 4 is clear and odd parity when it is set.
- R3: Control bit 5 inverts the incoming line and control bit 6 inverts the outgoing line. With bit 6 set, an idle line is low.
- R4: With control bit 7 set, `tx` equals `rx` XOR control bit 6, one clock after `rx` changes.
- R5: A write to address 2 stores the word and sets TxFull (status bit 0). The transmitter starts a frame only while control bit 0 is set. Otherwise `tx` stays idle.
- R6: When a frame ends and TxFull is set, the next frame starts with no idle gap, and loading the word clears TxFull. TxBusy (status bit 1) is high while a frame is being shifted out.
- R7: `tx_irq` is a single-cycle pulse, raised one cycle after each 1-to-0 transition of TxFull.
- R8: A write to address 2 while TxFull is set replaces the pending word. Only the last word is sent.
- R9: The divider value D (address 1) sets the bit period to 16*(D+1) clock cycles.
- R10: RxBusy (status bit 3) goes high once a valid start bit is seen. When the stop bit is sampled, the word moves to the receive data register (read at address 2) and RxFull (status bit 2) is set. Reading address 2 clears RxFull.
- R11: A low pulse on the receive line that has gone high again by the middle of the start bit does not start a reception.
- R12: Status bit 4 shows a parity mismatch and status bit 5 shows a low stop bit, both for the last received frame.
- R13: After reset, `tx` is high, `tx_irq` is low and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe. Data appears on `rdata` one cycle later |
| addr | input | 2 | Register address: 0 control, 1 divider, 2 data, 3 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx | input | 1 | Serial input line |
| tx | output | 1 | Serial output line, registered |
| tx_irq | output | 1 | Transmit-holding-empty pulse |

## Verification
The checks assume that the controller does not write a new word in the same cycle the transmitter loads the previous one. In that cycle TxFull never falls, so no pulse is expected. The stimulus writes either while the transmitter is disabled or well inside a running frame. The checks also assume that `rx` changes only at clock-aligned points. The bench drives `rx` from a behavioural frame generator that holds each level for a whole number of bit periods. It drives the register bus only away from the clock edge.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIV  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic echo;
    logic inv_tx;
    logic inv_rx;
    logic par_odd;
    logic par_en;
    logic len8;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  // serial image of one frame, bit 0 leaves first, unused tail is ones
  function automatic logic [10:0] make_frame(input logic [7:0] d, input logic len8,
                                             input logic pen, input logic odd);
    logic [10:0] f;
    logic p;
    f = '1;
    f[0] = 1'b0;
    p = odd;
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || len8) begin
        f[i+1] = d[i];
        p = p ^ d[i];
      end
    end
    if (pen) begin
      if (len8) f[9] = p;
      else      f[8] = p;
    end
    return f;
  endfunction

  function automatic logic [3:0] frame_len(input logic len8, input logic pen);
    return 4'd9 + {3'd0, len8} + {3'd0, pen};
  endfunction

endpackage

// File: rtl/uart_tick.sv
module uart_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_echo_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic       len8,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       full,
  output logic       busy,
  output logic       line,
  output logic       irq
);
  localparam int SW = $clog2(OVS);
  localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);

  logic [7:0]    hold;
  logic [10:0]   sh;
  logic [SW-1:0] sub;
  logic [3:0]    left;
  logic          full_q;
  logic          bit_end, load;

  assign bit_end = tick && busy && (sub == SUB_LAST);
  assign load    = full && en && tick && (!busy || (bit_end && left == 4'd1));
  assign line    = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= '0;
      sh     <= '1;
      sub    <= '0;
      left   <= '0;
      busy   <= 1'b0;
      full   <= 1'b0;
      full_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      full_q <= full;
      irq    <= full_q && !full;
      if (tick && busy) begin
        if (bit_end) begin
          sub <= '0;
          if (left == 4'd1) begin
            busy <= 1'b0;
          end else begin
            sh   <= {1'b1, sh[10:1]};
            left <= left - 4'd1;
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
      if (load) begin
        sh   <= make_frame(hold, len8, par_en, par_odd);
        left <= frame_len(len8, par_en);
        sub  <= '0;
        busy <= 1'b1;
        full <= 1'b0;
      end
      if (wr) begin
        hold <= wdata;
        full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_echo_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic       len8,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       line,
  input  logic       clr,
  output logic [7:0] data,
  output logic       full,
  output logic       busy,
  output logic       perr,
  output logic       ferr
);
  localparam int SW = $clog2(OVS);
  localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
  localparam logic [SW-1:0] SUB_MID  = SW'(OVS / 2 - 1);

  rx_st_t        st;
  logic [SW-1:0] sub;
  logic [3:0]    idx, n_data;
  logic [7:0]    sh;
  logic          acc, p_bad;

  assign n_data = len8 ? 4'd8 : 4'd7;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE; sub <= '0; idx <= '0; sh <= '0; acc <= 1'b0; p_bad <= 1'b0;
      data <= '0; full <= 1'b0; busy <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      if (clr) full <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (en && !line) begin
            st  <= RX_START;
            sub <= '0;
          end
          RX_START: if (sub == SUB_MID) begin
            sub <= '0;
            if (!line) begin
              st <= RX_BITS; busy <= 1'b1; idx <= '0; sh <= '0;
              acc <= par_odd; p_bad <= 1'b0;
            end else begin
              st <= RX_IDLE;
            end
          end else begin
            sub <= sub + 1'b1;
          end
          default: if (sub == SUB_LAST) begin
            sub <= '0;
            if (idx < n_data) begin
              sh[idx[2:0]] <= line;
              acc <= acc ^ line;
              idx <= idx + 4'd1;
            end else if (par_en && idx == n_data) begin
              p_bad <= line != acc;
              idx   <= idx + 4'd1;
            end else begin
              data <= sh;
              full <= 1'b1;
              ferr <= !line;
              perr <= par_en && p_bad;
              busy <= 1'b0;
              st   <= RX_IDLE;
            end
          end else begin
            sub <= sub + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_echo_core.sv
module uart_echo_core
  import uart_echo_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rx,
  output logic       tx,
  output logic       tx_irq
);
  ctrl_t            ctrl;
  logic [DIV_W-1:0] div;
  logic             tick, rx_s1, rx_s2, rx_line;
  logic             tx_full, tx_busy, tx_line;
  logic [7:0]       rx_data;
  logic             rx_full, rx_busy, rx_perr, rx_ferr;
  logic             wr_data, rd_data;

  assign wr_data = wr_en && addr == A_DATA;
  assign rd_data = rd_en && addr == A_DATA;
  assign rx_line = rx_s2 ^ ctrl.inv_rx;

  uart_tick #(.DIV_W(DIV_W)) i_tick (.clk(clk), .rst(rst), .div(div), .tick(tick));

  uart_tx #(.OVS(OVS)) i_tx (
    .clk(clk), .rst(rst), .tick(tick), .en(ctrl.tx_en), .len8(ctrl.len8),
    .par_en(ctrl.par_en), .par_odd(ctrl.par_odd), .wr(wr_data), .wdata(wdata),
    .full(tx_full), .busy(tx_busy), .line(tx_line), .irq(tx_irq));

  uart_rx #(.OVS(OVS)) i_rx (
    .clk(clk), .rst(rst), .tick(tick), .en(ctrl.rx_en), .len8(ctrl.len8),
    .par_en(ctrl.par_en), .par_odd(ctrl.par_odd), .line(rx_line), .clr(rd_data),
    .data(rx_data), .full(rx_full), .busy(rx_busy), .perr(rx_perr), .ferr(rx_ferr));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      div   <= '0;
      rdata <= '0;
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
      tx    <= 1'b1;
    end else begin
      rx_s1 <= rx;
      rx_s2 <= rx_s1;
      tx    <= (ctrl.echo ? rx : tx_line) ^ ctrl.inv_tx;
      if (wr_en && addr == A_CTRL) ctrl <= ctrl_t'(wdata);
      if (wr_en && addr == A_DIV)  div  <= DIV_W'(wdata);
      if (rd_en) begin
        case (addr)
          A_CTRL:  rdata <= ctrl;
          A_DIV:   rdata <= 8'(div);
          A_DATA:  rdata <= rx_data;
          default: rdata <= {2'b00, rx_ferr, rx_perr, rx_busy, rx_full, tx_busy, tx_full};
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_echo_chk.sv
module uart_echo_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic       tx_full,
  input logic       tx_busy,
  input logic       tx_irq,
  input logic       rx_full,
  input logic       rx_busy,
  input logic       echo,
  input logic       inv_tx,
  input logic       rx,
  input logic       tx
);
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst) tx_irq |=> !tx_irq);
  // R7
  irq_after_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(tx_full) |=> tx_irq);
  // R5
  full_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_full) |-> $past(wr_en && addr == 2'd2));
  // R4
  echo_path_chk: assert property (@(posedge clk) disable iff (rst)
    echo |=> tx == ($past(rx) ^ $past(inv_tx)));
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_busy && !echo) |=> tx == !$past(inv_tx));
  // R10
  rx_handoff_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> ($past(rx_busy) && !rx_busy));
endmodule

bind uart_echo_core uart_echo_chk i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .tx_full(tx_full),
  .tx_busy(tx_busy), .tx_irq(tx_irq), .rx_full(rx_full), .rx_busy(rx_busy),
  .echo(ctrl.echo), .inv_tx(ctrl.inv_tx), .rx(rx), .tx(tx));

// File: tb/test_uart_echo_core.sv
module test_uart_echo_core;
  localparam int CLK_NS = 10;
  localparam int BP     = 32;   // bit period with divider 1

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, rx = 1;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  wire  [7:0] rdata;
  wire  tx, tx_irq;
  int   n_tests = 0, n_fail = 0, irq_cnt = 0;
  bit   finished = 0;

  uart_echo_core i_uart_echo_core (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rx(rx), .tx(tx), .tx_irq(tx_irq));

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) if (!rst && tx_irq) irq_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  // expected serial bits, built as a queue
  function automatic logic [10:0] expect_bits(input logic [7:0] d, input int n,
                                              input bit pen, input bit odd);
    bit q[$];
    int ones = 0;
    logic [10:0] r = '1;
    q.push_back(0);
    for (int i = 0; i < n; i++) begin q.push_back(d[i]); ones += d[i]; end
    if (pen) q.push_back(((ones % 2) == 1) ^ odd);
    q.push_back(1);
    foreach (q[i]) r[i] = q[i];
    return r;
  endfunction

  task automatic get_frame(input int nb, input bit chained, input bit inv,
                           output logic [10:0] bits);
    bits = '1;
    if (!chained) begin
      do @(negedge clk); while ((tx ^ inv) == 1'b1);
      repeat (BP/2) @(negedge clk);
    end else begin
      repeat (BP) @(negedge clk);
    end
    bits[0] = tx ^ inv;
    for (int i = 1; i < nb; i++) begin
      repeat (BP) @(negedge clk);
      bits[i] = tx ^ inv;
    end
  endtask

  task automatic send_rx(input logic [7:0] d, input int n, input bit pen, input bit odd,
                         input bit flip, input bit stopv, input bit inv);
    int ones = 0;
    rx = 1'b0 ^ inv; repeat (BP) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx = d[i] ^ inv; ones += d[i]; repeat (BP) @(negedge clk);
    end
    if (pen) begin
      rx = (((ones % 2) == 1) ^ odd ^ flip) ^ inv; repeat (BP) @(negedge clk);
    end
    rx = stopv ^ inv; repeat (BP) @(negedge clk);
    rx = 1'b1 ^ inv;
  endtask

  task automatic tx_case(input logic [7:0] d, input int n, input bit pen, input bit odd,
                         input bit inv, input string req);
    logic [10:0] got, exp;
    int irq0 = irq_cnt;
    exp = expect_bits(d, n, pen, odd);
    fork
      get_frame(n + 2 + int'(pen), 0, inv, got);
      wr(2'd2, d);
    join
    repeat (BP) @(negedge clk);
    chk(got == exp, req, got, exp);
    chk(irq_cnt == irq0 + 1, "R7 one pulse per load", irq_cnt - irq0, 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    if (!finished) begin
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [10:0] f1, f2;
    int lowc, bad;
    repeat (3) @(negedge clk); rst = 0;
    // R13 reset state
    @(negedge clk);
    chk(tx == 1'b1 && tx_irq == 1'b0, "R13 tx/irq after reset", {tx, tx_irq}, 2'b10);
    rd(2'd3, v); chk(v == 8'h00, "R13 status after reset", v, 0);

    wr(2'd1, 8'd1);
    wr(2'd0, 8'h07);
    tx_case(8'hA5, 8, 0, 0, 0, "R1 8-bit frame");
    // R6 busy flag mid-frame
    fork
      get_frame(10, 0, 0, f1);
      begin wr(2'd2, 8'h3C); repeat (100) @(negedge clk); rd(2'd3, v);
            chk(v[1:0] == 2'b10, "R6 busy while shifting", v[1:0], 2); end
    join
    repeat (BP) @(negedge clk);
    wr(2'd0, 8'h0B);
    tx_case(8'h35, 7, 1, 0, 0, "R1 R2 7-bit even parity");
    wr(2'd0, 8'h1F);
    tx_case(8'h5C, 8, 1, 1, 0, "R2 8-bit odd parity");

    // R6 back to back
    wr(2'd0, 8'h07);
    bad = irq_cnt;
    fork
      begin get_frame(10, 0, 0, f1); get_frame(10, 1, 0, f2); end
      begin wr(2'd2, 8'h3A); repeat (50) @(negedge clk); wr(2'd2, 8'hC3); end
    join
    repeat (BP) @(negedge clk);
    chk(f1 == expect_bits(8'h3A, 8, 0, 0), "R6 first chained frame", f1, expect_bits(8'h3A, 8, 0, 0));
    chk(f2 == expect_bits(8'hC3, 8, 0, 0), "R6 second frame with no gap", f2, expect_bits(8'hC3, 8, 0, 0));
    chk(irq_cnt == bad + 2, "R7 two pulses", irq_cnt - bad, 2);
    rd(2'd3, v); chk(v[1:0] == 2'b00, "R6 flags clear after", v[1:0], 0);

    // R5 R8 disabled transmitter, overwrite
    wr(2'd0, 8'h06);
    wr(2'd2, 8'h11); wr(2'd2, 8'h22);
    bad = 0;
    repeat (200) begin @(negedge clk); if (tx !== 1'b1) bad++; end
    chk(bad == 0, "R5 idle while disabled", bad, 0);
    rd(2'd3, v); chk(v[0] == 1'b1, "R5 TxFull after write", v[0], 1);
    fork
      get_frame(10, 0, 0, f1);
      wr(2'd0, 8'h07);
    join
    chk(f1 == expect_bits(8'h22, 8, 0, 0), "R8 last word sent", f1, expect_bits(8'h22, 8, 0, 0));
    bad = 0;
    repeat (400) begin @(negedge clk); if (tx !== 1'b1) bad++; end
    chk(bad == 0, "R8 old word dropped", bad, 0);

    // R3 inverted output
    wr(2'd0, 8'h47);
    repeat (4) @(negedge clk);
    chk(tx == 1'b0, "R3 inverted idle", tx, 0);
    tx_case(8'h96, 8, 0, 0, 1, "R3 inverted frame");
    wr(2'd0, 8'h07);

    // R9 bit period with divider 3
    wr(2'd1, 8'd3);
    fork
      begin
        do @(negedge clk); while (tx == 1'b1);
        lowc = 0;
        while (tx == 1'b0) begin lowc++; @(negedge clk); end
      end
      wr(2'd2, 8'h00);
    join
    chk(lowc == 9 * 64, "R9 bit period", lowc, 9 * 64);
    repeat (80) @(negedge clk);
    wr(2'd1, 8'd1);

    // R10 receive
    fork
      send_rx(8'h3C, 8, 0, 0, 0, 1, 0);
      begin repeat (100) @(negedge clk); rd(2'd3, v);
            chk(v[3] == 1'b1, "R10 RxBusy during frame", v[3], 1); end
    join
    repeat (4) @(negedge clk);
    rd(2'd3, v); chk(v[5:2] == 4'b0001, "R10 RxFull set, no errors", v[5:2], 1);
    rd(2'd2, v); chk(v == 8'h3C, "R10 received data", v, 8'h3C);
    rd(2'd3, v); chk(v[2] == 1'b0, "R10 RxFull cleared by read", v[2], 0);

    // R12 R2 parity error then clean
    wr(2'd0, 8'h0F);
    send_rx(8'h81, 8, 1, 0, 1, 1, 0);
    repeat (4) @(negedge clk);
    rd(2'd3, v); chk(v[4] == 1'b1, "R12 parity error flag", v[4], 1);
    rd(2'd2, v);
    send_rx(8'h81, 8, 1, 0, 0, 1, 0);
    repeat (4) @(negedge clk);
    rd(2'd3, v); chk(v[5:4] == 2'b00, "R2 good parity accepted", v[5:4], 0);
    rd(2'd2, v); chk(v == 8'h81, "R2 parity frame data", v, 8'h81);

    // R12 framing error
    wr(2'd0, 8'h07);
    send_rx(8'h55, 8, 0, 0, 0, 0, 0);
    repeat (64) @(negedge clk);
    rd(2'd3, v); chk(v[5] == 1'b1, "R12 framing error flag", v[5], 1);
    rd(2'd2, v);

    // R3 inverted input, 7-bit word
    rx = 1'b0;
    wr(2'd0, 8'h23);
    repeat (10) @(negedge clk);
    send_rx(8'h5A, 7, 0, 0, 0, 1, 1);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk(v == 8'h5A, "R3 inverted receive", v, 8'h5A);
    rx = 1'b1;
    wr(2'd0, 8'h07);
    repeat (80) @(negedge clk);
    rd(2'd3, v);

    // R11 short start pulse
    rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (60) @(negedge clk);
    rd(2'd3, v); chk(v[3:2] == 2'b00, "R11 glitch rejected", v[3:2], 0);

    // R4 echo with inverted output
    wr(2'd0, 8'hC7);
    rx = 1'b0; repeat (4) @(negedge clk);
    chk(tx == 1'b1, "R4 echo low in", tx, 1);
    rx = 1'b1; repeat (4) @(negedge clk);
    chk(tx == 1'b0, "R4 echo high in", tx, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule